// File: doc/BRIEF.md
# Doorbell Mailbox Channel Window

This block is one doorbell channel window as seen from both ends of a mailbox link. A sending agent and a receiving agent each reach the window through their own 32-bit register port. The window keeps a single word of independent doorbell flags that both agents see. The sender raises flags with a write-to-set register. The receiver drops flags with a write-to-clear register and decides which flags may interrupt it through a per-flag mask.

When the receiver clears a flag that was pending, the window raises a transfer-acknowledge event back towards the sender. That event sets a sticky status bit. The sender gates the bit with an enable and clears it through a write-one-to-clear register. Each side also has a control bit that lets its interrupt feed a combined interrupt line. The register ports are plain control ports, not streams: a request is taken in the cycle it is presented, and nothing is ever stalled. Read data and a read-valid strobe come out one cycle after the read request.

Top module: `dbw_window`

## Requirements
- R1: After reset, all flags are 0, every receiver mask bit is 1 (masked), the acknowledge status, the acknowledge enable and both control bits are 0, and every interrupt output is low.
- R2: A sender write to offset 0x0C sets each flag whose data bit is 1. Flags whose data bit is 0 keep their value. Offset 0x00 on either port reads the flag word.
- R3: A receiver write to offset 0x08 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: A receiver clear that drops at least one flag that was 1 sets the acknowledge status, which reads as bit 0 of sender offset 0x10. A clear that hits only flags that are 0 leaves the acknowledge status unchanged.
- R5: If a sender set and a receiver clear hit the same flag in the same cycle, the flag ends up 1, and that flag does not count towards the acknowledge event.
- R6: A receiver write to offset 0x14 sets mask bits, and a write to offset 0x18 clears mask bits, one bit per data bit that is 1. Offset 0x10 reads the mask. Offset 0x04 reads the flags ANDed with the inverse of the mask.
- R7: `rx_irq` is high exactly while the masked flag word is nonzero.
- R8: A sender write with bit 0 set to offset 0x14 clears the acknowledge status. A new acknowledge event in the same cycle wins over the clear. Bit 0 of sender offset 0x18 is the acknowledge enable, which can be read back. `tx_irq` is high exactly while both the acknowledge status and the enable are 1.
- R9: Bit 0 of offset 0x1C on each port is a read/write control bit. `tx_comb_irq` equals `tx_irq` AND the sender control bit. `rx_comb_irq` equals `rx_irq` AND the receiver control bit.
- R10: A read request returns its data, with the valid strobe high, in the next cycle. Write-only offsets and unmapped offsets read as 0. Writes to read-only offsets and to unmapped offsets change nothing. Register bits above bit 0 of single-bit registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Sender port access request |
| tx_we | input | 1 | Sender port write (1) or read (0) |
| tx_addr | input | 5 | Sender port byte offset |
| tx_wdata | input | FLAG_W | Sender port write data |
| tx_rvalid | output | 1 | Sender read data valid |
| tx_rdata | output | FLAG_W | Sender read data |
| rx_req | input | 1 | Receiver port access request |
| rx_we | input | 1 | Receiver port write (1) or read (0) |
| rx_addr | input | 5 | Receiver port byte offset |
| rx_wdata | input | FLAG_W | Receiver port write data |
| rx_rvalid | output | 1 | Receiver read data valid |
| rx_rdata | output | FLAG_W | Receiver read data |
| tx_irq | output | 1 | Sender acknowledge interrupt |
| tx_comb_irq | output | 1 | Sender contribution to the combined interrupt |
| rx_irq | output | 1 | Receiver doorbell interrupt |
| rx_comb_irq | output | 1 | Receiver contribution to the combined interrupt |

## Verification
The directed patterns separate the two halves of a doorbell exchange. A lone set against a lone clear checks that each write affects only the bits it names. A clear of flags that are already 0 shows whether the acknowledge event is tied to a real drop and not just to any clear write. A set and a clear landing on the same bit in the same cycle shows which one wins and whether a phantom acknowledge appears. A long random phase then drives both ports at once with sparse data, odd offsets and unmapped offsets. It brings out collisions between mask updates, acknowledge clears and fresh events. A behavioural model compares every output on every cycle.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int unsigned OFS_W = 5;

  // sender window
  localparam logic [OFS_W-1:0] TX_STAT_OFS = 5'h00;
  localparam logic [OFS_W-1:0] TX_SET_OFS  = 5'h0C;
  localparam logic [OFS_W-1:0] TX_ACK_OFS  = 5'h10;
  localparam logic [OFS_W-1:0] TX_ACLR_OFS = 5'h14;
  localparam logic [OFS_W-1:0] TX_AEN_OFS  = 5'h18;
  localparam logic [OFS_W-1:0] TX_CTL_OFS  = 5'h1C;

  // receiver window
  localparam logic [OFS_W-1:0] RX_STAT_OFS = 5'h00;
  localparam logic [OFS_W-1:0] RX_MSTA_OFS = 5'h04;
  localparam logic [OFS_W-1:0] RX_CLR_OFS  = 5'h08;
  localparam logic [OFS_W-1:0] RX_MASK_OFS = 5'h10;
  localparam logic [OFS_W-1:0] RX_MSET_OFS = 5'h14;
  localparam logic [OFS_W-1:0] RX_MCLR_OFS = 5'h18;
  localparam logic [OFS_W-1:0] RX_CTL_OFS  = 5'h1C;

  localparam int unsigned SIDES   = 2;
  localparam int unsigned SIDE_TX = 0;
  localparam int unsigned SIDE_RX = 1;
endpackage

// File: rtl/dbw_flag_store.sv
module dbw_flag_store #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags_q,
  output logic              ack_evt
);
  logic [FLAG_W-1:0] dropped;
  logic [FLAG_W-1:0] flags_d;

  // a flag only counts as dropped when it was up and the sender is not re-raising it
  assign dropped = clr_vec & flags_q & ~set_vec;
  assign ack_evt = |dropped;
  assign flags_d = (flags_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((flags_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: rtl/dbw_rx_mask.sv
module dbw_rx_mask #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] mset_vec,
  input  logic [FLAG_W-1:0] mclr_vec,
  input  logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] mask_q,
  output logic [FLAG_W-1:0] masked
);
  logic [FLAG_W-1:0] mask_d;

  assign mask_d = (mask_q & ~mclr_vec) | mset_vec;
  assign masked = flags_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_vec != '0) |=> ((mask_q & $past(mset_vec)) == $past(mset_vec)));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mclr_vec & ~mset_vec) != '0) |=> ((mask_q & $past(mclr_vec & ~mset_vec)) == '0));
endmodule

// File: rtl/dbw_tx_ack.sv
module dbw_tx_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  input  logic ack_clr,
  input  logic en_we,
  input  logic en_d,
  output logic ack_q,
  output logic en_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (ack_evt)      ack_q <= 1'b1;
      else if (ack_clr) ack_q <= 1'b0;
      if (en_we)        en_q  <= en_d;
    end
  end

  assign irq = ack_q & en_q;

  // R4
  ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> ack_q);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !ack_evt) |=> !ack_q);
endmodule

// File: rtl/dbw_window.sv
module dbw_window #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_req,
  input  logic                      tx_we,
  input  logic [dbw_pkg::OFS_W-1:0] tx_addr,
  input  logic [FLAG_W-1:0]         tx_wdata,
  output logic                      tx_rvalid,
  output logic [FLAG_W-1:0]         tx_rdata,
  input  logic                      rx_req,
  input  logic                      rx_we,
  input  logic [dbw_pkg::OFS_W-1:0] rx_addr,
  input  logic [FLAG_W-1:0]         rx_wdata,
  output logic                      rx_rvalid,
  output logic [FLAG_W-1:0]         rx_rdata,
  output logic                      tx_irq,
  output logic                      tx_comb_irq,
  output logic                      rx_irq,
  output logic                      rx_comb_irq
);
  import dbw_pkg::*;

  localparam int unsigned PAD_W = FLAG_W - 1;

  logic tx_wr, tx_rd, rx_wr, rx_rd;
  assign tx_wr = tx_req &  tx_we;
  assign tx_rd = tx_req & ~tx_we;
  assign rx_wr = rx_req &  rx_we;
  assign rx_rd = rx_req & ~rx_we;

  // write strobes decoded into bit vectors
  logic [FLAG_W-1:0] set_vec, clr_vec, mset_vec, mclr_vec;
  assign set_vec  = (tx_wr && tx_addr == TX_SET_OFS)  ? tx_wdata : '0;
  assign clr_vec  = (rx_wr && rx_addr == RX_CLR_OFS)  ? rx_wdata : '0;
  assign mset_vec = (rx_wr && rx_addr == RX_MSET_OFS) ? rx_wdata : '0;
  assign mclr_vec = (rx_wr && rx_addr == RX_MCLR_OFS) ? rx_wdata : '0;

  logic [FLAG_W-1:0] flags_q, mask_q, masked;
  logic ack_evt, ack_q, aen_q, ack_irq;

  dbw_flag_store #(.FLAG_W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q),
    .ack_evt (ack_evt)
  );

  dbw_rx_mask #(.FLAG_W(FLAG_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .mset_vec (mset_vec),
    .mclr_vec (mclr_vec),
    .flags_q  (flags_q),
    .mask_q   (mask_q),
    .masked   (masked)
  );

  dbw_tx_ack u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_evt (ack_evt),
    .ack_clr (tx_wr && tx_addr == TX_ACLR_OFS && tx_wdata[0]),
    .en_we   (tx_wr && tx_addr == TX_AEN_OFS),
    .en_d    (tx_wdata[0]),
    .ack_q   (ack_q),
    .en_q    (aen_q),
    .irq     (ack_irq)
  );

  // combined-enable control bit, one per side
  logic [SIDES-1:0] ctl_we, ctl_d, ctl_q;
  assign ctl_we[SIDE_TX] = tx_wr && tx_addr == TX_CTL_OFS;
  assign ctl_d[SIDE_TX]  = tx_wdata[0];
  assign ctl_we[SIDE_RX] = rx_wr && rx_addr == RX_CTL_OFS;
  assign ctl_d[SIDE_RX]  = rx_wdata[0];

  for (genvar s = 0; s < SIDES; s++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctl_q[s] <= 1'b0;
      else if (ctl_we[s]) ctl_q[s] <= ctl_d[s];
    end
  end

  // read muxes
  logic [FLAG_W-1:0] tx_rmux, rx_rmux;
  always_comb begin
    case (tx_addr)
      TX_STAT_OFS: tx_rmux = flags_q;
      TX_ACK_OFS:  tx_rmux = {{PAD_W{1'b0}}, ack_q};
      TX_AEN_OFS:  tx_rmux = {{PAD_W{1'b0}}, aen_q};
      TX_CTL_OFS:  tx_rmux = {{PAD_W{1'b0}}, ctl_q[SIDE_TX]};
      default:     tx_rmux = '0;
    endcase
  end

  always_comb begin
    case (rx_addr)
      RX_STAT_OFS: rx_rmux = flags_q;
      RX_MSTA_OFS: rx_rmux = masked;
      RX_MASK_OFS: rx_rmux = mask_q;
      RX_CTL_OFS:  rx_rmux = {{PAD_W{1'b0}}, ctl_q[SIDE_RX]};
      default:     rx_rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rvalid <= 1'b0;
      tx_rdata  <= '0;
      rx_rvalid <= 1'b0;
      rx_rdata  <= '0;
    end else begin
      tx_rvalid <= tx_rd;
      tx_rdata  <= tx_rd ? tx_rmux : '0;
      rx_rvalid <= rx_rd;
      rx_rdata  <= rx_rd ? rx_rmux : '0;
    end
  end

  assign tx_irq      = ack_irq;
  assign tx_comb_irq = ack_irq & ctl_q[SIDE_TX];
  assign rx_irq      = |masked;
  assign rx_comb_irq = rx_irq & ctl_q[SIDE_RX];

  // R7
  rx_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (flags_q != '0));

  // R10
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !rx_we) |=> rx_rvalid);

  // R10
  wr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_req && !tx_we) |=> (!tx_rvalid && tx_rdata == '0));
endmodule

// File: tb/tb_dbw_window.sv
`timescale 1ns/1ps
module tb_dbw_window;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         tx_req = 0, tx_we = 0, rx_req = 0, rx_we = 0;
  logic [4:0]   tx_addr = '0, rx_addr = '0;
  logic [W-1:0] tx_wdata = '0, rx_wdata = '0;
  logic         tx_rvalid, rx_rvalid, tx_irq, tx_comb_irq, rx_irq, rx_comb_irq;
  logic [W-1:0] tx_rdata, rx_rdata;

  dbw_window #(.FLAG_W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .tx_rvalid(tx_rvalid), .tx_rdata(tx_rdata),
    .rx_req(rx_req), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .rx_rvalid(rx_rvalid), .rx_rdata(rx_rdata),
    .tx_irq(tx_irq), .tx_comb_irq(tx_comb_irq), .rx_irq(rx_irq), .rx_comb_irq(rx_comb_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference state
  logic [W-1:0] m_flags, m_mask;
  bit m_ack, m_en, m_tctl, m_rctl;
  logic [W-1:0] e_trd, e_rrd;
  bit e_trv, e_rrv;

  function automatic logic [W-1:0] tx_view(logic [4:0] a);
    if (a == 5'h00) return m_flags;
    if (a == 5'h10) return W'(m_ack);
    if (a == 5'h18) return W'(m_en);
    if (a == 5'h1C) return W'(m_tctl);
    return '0;
  endfunction

  function automatic logic [W-1:0] rx_view(logic [4:0] a);
    if (a == 5'h00) return m_flags;
    if (a == 5'h04) return m_flags & ~m_mask;
    if (a == 5'h10) return m_mask;
    if (a == 5'h1C) return W'(m_rctl);
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0; m_mask = '1; m_ack = 0; m_en = 0; m_tctl = 0; m_rctl = 0;
      e_trd = '0; e_rrd = '0; e_trv = 0; e_rrv = 0;
    end else begin
      logic [W-1:0] s, c;
      bit hit;
      e_trv = tx_req && !tx_we;
      e_rrv = rx_req && !rx_we;
      e_trd = e_trv ? tx_view(tx_addr) : '0;
      e_rrd = e_rrv ? rx_view(rx_addr) : '0;
      s = (tx_req && tx_we && tx_addr == 5'h0C) ? tx_wdata : '0;
      c = (rx_req && rx_we && rx_addr == 5'h08) ? rx_wdata : '0;
      hit = 0;
      for (int i = 0; i < W; i++)
        if (c[i] && m_flags[i] && !s[i]) hit = 1;
      for (int i = 0; i < W; i++) begin
        if (s[i]) m_flags[i] = 1'b1;
        else if (c[i]) m_flags[i] = 1'b0;
      end
      if (hit) m_ack = 1;
      else if (tx_req && tx_we && tx_addr == 5'h14 && tx_wdata[0]) m_ack = 0;
      if (tx_req && tx_we && tx_addr == 5'h18) m_en = tx_wdata[0];
      if (tx_req && tx_we && tx_addr == 5'h1C) m_tctl = tx_wdata[0];
      if (rx_req && rx_we && rx_addr == 5'h1C) m_rctl = rx_wdata[0];
      if (rx_req && rx_we && rx_addr == 5'h14) m_mask = m_mask | rx_wdata;
      if (rx_req && rx_we && rx_addr == 5'h18) m_mask = m_mask & ~rx_wdata;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10", "tx_rvalid", W'(tx_rvalid), W'(e_trv));
      check("R10", "tx_rdata",  tx_rdata, e_trd);
      check("R10", "rx_rvalid", W'(rx_rvalid), W'(e_rrv));
      check("R10", "rx_rdata",  rx_rdata, e_rrd);
      check("R8",  "tx_irq",    W'(tx_irq), W'(m_ack & m_en));
      check("R9",  "tx_comb_irq", W'(tx_comb_irq), W'(m_ack & m_en & m_tctl));
      check("R7",  "rx_irq",    W'(rx_irq), W'(|(m_flags & ~m_mask)));
      check("R9",  "rx_comb_irq", W'(rx_comb_irq), W'((|(m_flags & ~m_mask)) & m_rctl));
    end
  end

  task automatic drive(bit tq, bit tw, logic [4:0] ta, logic [W-1:0] td,
                       bit rq, bit rw, logic [4:0] ra, logic [W-1:0] rd);
    @(negedge clk);
    tx_req = tq; tx_we = tw; tx_addr = ta; tx_wdata = td;
    rx_req = rq; rx_we = rw; rx_addr = ra; rx_wdata = rd;
  endtask

  task automatic idle();
    drive(0, 0, 5'h00, '0, 0, 0, 5'h00, '0);
  endtask
  task automatic tx_wr(logic [4:0] a, logic [W-1:0] d);
    drive(1, 1, a, d, 0, 0, 5'h00, '0); idle();
  endtask
  task automatic rx_wr(logic [4:0] a, logic [W-1:0] d);
    drive(0, 0, 5'h00, '0, 1, 1, a, d); idle();
  endtask
  task automatic tx_rd(logic [4:0] a, logic [W-1:0] exp, string tag);
    drive(1, 0, a, '0, 0, 0, 5'h00, '0); idle();
    check(tag, "tx read", tx_rdata, exp);
  endtask
  task automatic rx_rd(logic [4:0] a, logic [W-1:0] exp, string tag);
    drive(0, 0, 5'h00, '0, 1, 0, a, '0); idle();
    check(tag, "rx read", rx_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    check("R1", "irqs", W'({tx_irq, tx_comb_irq, rx_irq, rx_comb_irq}), '0);
    rx_rd(5'h10, 32'hFFFF_FFFF, "R1");
    tx_rd(5'h00, 32'h0, "R1");
    tx_rd(5'h18, 32'h0, "R1");
    tx_rd(5'h10, 32'h0, "R1");
    // R2 set, zeros have no effect
    tx_wr(5'h0C, 32'h0000_00A5);
    tx_rd(5'h00, 32'h0000_00A5, "R2");
    tx_wr(5'h0C, 32'h0);
    rx_rd(5'h00, 32'h0000_00A5, "R2");
    // R3 / R4 clear raises acknowledge
    rx_wr(5'h08, 32'h0000_0005);
    rx_rd(5'h00, 32'h0000_00A0, "R3");
    tx_rd(5'h10, 32'h1, "R4");
    // R8 acknowledge clear
    tx_wr(5'h14, 32'h1);
    tx_rd(5'h10, 32'h0, "R8");
    // R4 clearing an idle flag raises nothing
    rx_wr(5'h08, 32'h0000_0100);
    tx_rd(5'h10, 32'h0, "R4");
    // R5 same-cycle set and clear
    drive(1, 1, 5'h0C, 32'h1, 1, 1, 5'h08, 32'h1); idle();
    rx_rd(5'h00, 32'h0000_00A1, "R5");
    tx_rd(5'h10, 32'h0, "R5");
    // R6 / R7 masking
    rx_wr(5'h18, 32'h0000_0080);
    rx_rd(5'h10, 32'hFFFF_FF7F, "R6");
    rx_rd(5'h04, 32'h0000_0080, "R6");
    check("R7", "rx_irq unmasked", W'(rx_irq), W'(1));
    rx_wr(5'h14, 32'h0000_0080);
    check("R7", "rx_irq remasked", W'(rx_irq), W'(0));
    // R8 / R9 interrupt gating
    tx_wr(5'h18, 32'h1);
    tx_rd(5'h18, 32'h1, "R8");
    rx_wr(5'h08, 32'h0000_0020);
    check("R8", "tx_irq", W'(tx_irq), W'(1));
    check("R9", "tx_comb_irq off", W'(tx_comb_irq), W'(0));
    tx_wr(5'h1C, 32'hFFFF_FFFF);
    tx_rd(5'h1C, 32'h1, "R9");
    check("R9", "tx_comb_irq on", W'(tx_comb_irq), W'(1));
    rx_wr(5'h1C, 32'h1);
    rx_wr(5'h18, 32'h0000_0080);
    check("R9", "rx_comb_irq on", W'(rx_comb_irq), W'(1));
    // R8 event beats clear in the same cycle
    drive(1, 1, 5'h14, 32'h1, 1, 1, 5'h08, 32'h0000_0080); idle();
    tx_rd(5'h10, 32'h1, "R8");
    // R10 write-only / unmapped reads and ignored writes
    tx_rd(5'h04, 32'h0, "R10");
    tx_rd(5'h0C, 32'h0, "R10");
    rx_rd(5'h08, 32'h0, "R10");
    rx_wr(5'h00, 32'hFFFF_FFFF);
    rx_rd(5'h00, 32'h0000_0001, "R10");
    // random phase on both ports, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ta, ra;
      logic [W-1:0] td, rd;
      ta = ($urandom % 10 == 0) ? 5'($urandom) : {3'($urandom), 2'b00};
      ra = ($urandom % 10 == 0) ? 5'($urandom) : {3'($urandom), 2'b00};
      td = $urandom & $urandom & $urandom;
      rd = $urandom & $urandom;
      drive(1'($urandom), 1'($urandom), ta, td, 1'($urandom), 1'($urandom), ra, rd);
    end
    idle(); idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule